// File: doc/BRIEF.md
# Programmable Clock-Enable Prescaler Chain

This block models a microcontroller clock tree in a single fast reference domain. All of its outputs are single-cycle enable pulses, not real clocks. An internal divider turns the reference into an internal-source enable, with a division of 1 to 128 in powers of two. A selector then picks the system enable from that internal enable or from one of four external source enables. The external enables model a fast crystal, the multiplier output, a slow RC oscillator and a slow crystal.

The system enable drives a bus prescaler (1 to 512). The bus enable in turn drives a fixed divide-by-eight tap and a peripheral prescaler (1 to 16). A timer enable is derived from the peripheral enable. The source and the three programmable divisors are loaded together through a single write strobe. Each new value is applied only at a safe boundary, so no pulse period is ever cut short.

Top module: `ckp_chain`

## Requirements
- R1: After reset the internal source is selected and every programmable divisor is 1. From the first cycle after reset, int_en_o, sys_en_o, bus_en_o, per_en_o and tmr_en_o are all high on every cycle.
- R2: int_en_o pulses once every 2^c reference cycles, where c is the 3-bit internal divider code (0 to 7).
- R3: Source code 0 selects the internal enable, 1 ext_hi_en_i, 2 pll_en_i, 3 rc_lo_en_i and 4 ext_lo_en_i. Codes 5 to 7 select the internal enable. sys_en_o equals the selected enable.
- R4: A new source takes effect in the cycle after the next sys_en_o pulse. A source switch does not reset any downstream counter.
- R5: bus_en_o pulses on every 2^c-th sys_en_o pulse, with the 4-bit code c in 0 to 9. Codes 10 to 15 give a divisor of 512.
- R6: bus8_en_o pulses on every eighth bus_en_o pulse, counted from reset.
- R7: per_en_o pulses on every 2^c-th bus_en_o pulse, with the 3-bit code c in 0 to 4. Codes 5 to 7 give a divisor of 16.
- R8: With a peripheral divisor of 1, tmr_en_o equals per_en_o. With any other divisor, tmr_en_o also pulses on the bus enable halfway through each peripheral period, which gives twice the peripheral rate.
- R9: A divisor written to a stage takes effect only at that stage's next output pulse. The period in progress completes at the old length.
- R10: bus_en_o is high only when sys_en_o is high. bus8_en_o, per_en_o and tmr_en_o are high only when bus_en_o is high.
- R11: Configuration inputs are captured only on cycles with cfg_we_i high. At other times they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Capture all configuration fields |
| cfg_src_i | input | 3 | System source code |
| cfg_int_div_i | input | 3 | Internal divider code (log2) |
| cfg_bus_div_i | input | 4 | Bus prescaler code (log2) |
| cfg_per_div_i | input | 3 | Peripheral prescaler code (log2) |
| ext_hi_en_i | input | 1 | Fast external source enable |
| pll_en_i | input | 1 | Multiplier output enable |
| rc_lo_en_i | input | 1 | Slow RC source enable |
| ext_lo_en_i | input | 1 | Slow crystal source enable |
| int_en_o | output | 1 | Divided internal-source enable |
| sys_en_o | output | 1 | System enable |
| bus_en_o | output | 1 | Bus enable |
| bus8_en_o | output | 1 | Bus enable divided by eight |
| per_en_o | output | 1 | Peripheral enable |
| tmr_en_o | output | 1 | Timer enable |

## Verification
The external source enables are driven as random pulse trains with different densities, so a wrong source selection or a late switch changes which pulses the chain counts. The configuration fields change every cycle while the write strobe stays low. This shows whether uncaptured values leak into the chain. Rare random writes across the whole code range, including the saturating codes, apply new divisors in the middle of a period, which tells deferred loading apart from immediate loading. Directed writes cover the reset divisors, a peripheral divisor of 1 against the larger divisors for the timer enable, and the out-of-range source codes.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
  typedef enum logic [2:0] {
    SRC_INT    = 3'd0,
    SRC_EXT_HI = 3'd1,
    SRC_PLL    = 3'd2,
    SRC_RC_LO  = 3'd3,
    SRC_EXT_LO = 3'd4
  } src_e;

  localparam int unsigned NUM_SRC = 5;

  function automatic src_e map_src(input logic [2:0] code);
    return (code < 3'(NUM_SRC)) ? src_e'(code) : SRC_INT;
  endfunction
endpackage

// File: rtl/ckp_div.sv
// Power-of-two enable divider; new code is loaded only at the wrap pulse.
module ckp_div #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned MAX_CODE = 7,
  parameter int unsigned RST_CODE = 0,
  localparam int unsigned CNT_W   = (MAX_CODE > 0) ? MAX_CODE : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic              half_o,
  output logic              one_o
);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] RST_C = CODE_W'(RST_CODE);

  logic [CODE_W-1:0] act_q, code_sat;
  logic [CNT_W-1:0]  cnt_q, lim, half_lim;
  logic [CNT_W:0]    span;
  logic              wrap;

  assign code_sat = (code_i > MAX_C) ? MAX_C : code_i;
  assign span     = {{CNT_W{1'b0}}, 1'b1} << act_q;
  assign lim      = CNT_W'(span - 1'b1);
  assign half_lim = CNT_W'((span >> 1) - 1'b1);
  assign wrap     = en_i && (cnt_q == lim);
  assign en_o     = wrap;
  assign one_o    = (act_q == '0);
  assign half_o   = en_i && !one_o && (cnt_q == half_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RST_C;
    end else if (wrap) begin
      cnt_q <= '0;
      act_q <= code_sat;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ckp_src_sel.sv
// Source switch is applied on a pulse of the current source.
module ckp_src_sel
  import ckp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [2:0]         src_code_i,
  output logic               sys_en_o
);
  src_e sel_q;

  assign sys_en_o = src_en_i[sel_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= SRC_INT;
    else if (sys_en_o) sel_q <= map_src(src_code_i);
  end
endmodule

// File: rtl/ckp_chain.sv
module ckp_chain
  import ckp_pkg::*;
#(
  parameter int unsigned INT_CODE_W = 3,
  parameter int unsigned INT_MAX    = 7,
  parameter int unsigned BUS_CODE_W = 4,
  parameter int unsigned BUS_MAX    = 9,
  parameter int unsigned PER_CODE_W = 3,
  parameter int unsigned PER_MAX    = 4,
  parameter int unsigned TAP_LOG2   = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [2:0]            cfg_src_i,
  input  logic [INT_CODE_W-1:0] cfg_int_div_i,
  input  logic [BUS_CODE_W-1:0] cfg_bus_div_i,
  input  logic [PER_CODE_W-1:0] cfg_per_div_i,
  input  logic                  ext_hi_en_i,
  input  logic                  pll_en_i,
  input  logic                  rc_lo_en_i,
  input  logic                  ext_lo_en_i,
  output logic                  int_en_o,
  output logic                  sys_en_o,
  output logic                  bus_en_o,
  output logic                  bus8_en_o,
  output logic                  per_en_o,
  output logic                  tmr_en_o
);
  localparam int unsigned TAP_W = $clog2(TAP_LOG2 + 1);

  logic [2:0]            src_q;
  logic [INT_CODE_W-1:0] int_q;
  logic [BUS_CODE_W-1:0] bus_q;
  logic [PER_CODE_W-1:0] per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 3'(SRC_INT);
      int_q <= '0;
      bus_q <= '0;
      per_q <= '0;
    end else if (cfg_we_i) begin
      src_q <= cfg_src_i;
      int_q <= cfg_int_div_i;
      bus_q <= cfg_bus_div_i;
      per_q <= cfg_per_div_i;
    end
  end

  logic unused_int_half, unused_int_one, unused_bus_half, unused_bus_one;
  logic unused_tap_half, unused_tap_one;
  logic per_half, per_one;

  ckp_div #(.CODE_W(INT_CODE_W), .MAX_CODE(INT_MAX)) i_int_div (
    .clk_i, .rst_ni, .en_i(1'b1), .code_i(int_q),
    .en_o(int_en_o), .half_o(unused_int_half), .one_o(unused_int_one)
  );

  ckp_src_sel i_src_sel (
    .clk_i, .rst_ni,
    .src_en_i({ext_lo_en_i, rc_lo_en_i, pll_en_i, ext_hi_en_i, int_en_o}),
    .src_code_i(src_q), .sys_en_o(sys_en_o)
  );

  ckp_div #(.CODE_W(BUS_CODE_W), .MAX_CODE(BUS_MAX)) i_bus_div (
    .clk_i, .rst_ni, .en_i(sys_en_o), .code_i(bus_q),
    .en_o(bus_en_o), .half_o(unused_bus_half), .one_o(unused_bus_one)
  );

  ckp_div #(.CODE_W(TAP_W), .MAX_CODE(TAP_LOG2), .RST_CODE(TAP_LOG2)) i_tap_div (
    .clk_i, .rst_ni, .en_i(bus_en_o), .code_i(TAP_W'(TAP_LOG2)),
    .en_o(bus8_en_o), .half_o(unused_tap_half), .one_o(unused_tap_one)
  );

  ckp_div #(.CODE_W(PER_CODE_W), .MAX_CODE(PER_MAX)) i_per_div (
    .clk_i, .rst_ni, .en_i(bus_en_o), .code_i(per_q),
    .en_o(per_en_o), .half_o(per_half), .one_o(per_one)
  );

  assign tmr_en_o = per_one ? per_en_o : (per_en_o | per_half);
endmodule

// File: rtl/ckp_chain_chk.sv
module ckp_chain_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ext_hi_en_i,
  input logic pll_en_i,
  input logic rc_lo_en_i,
  input logic ext_lo_en_i,
  input logic int_en_o,
  input logic sys_en_o,
  input logic bus_en_o,
  input logic bus8_en_o,
  input logic per_en_o,
  input logic tmr_en_o
);
  assert_bus_in_sys_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> sys_en_o);
  assert_tap_in_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus8_en_o |-> bus_en_o);
  assert_per_in_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> bus_en_o);
  assert_tmr_in_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_en_o |-> bus_en_o);
  assert_tmr_covers_per_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> tmr_en_o);
  assert_sys_has_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |-> (int_en_o | ext_hi_en_i | pll_en_i | rc_lo_en_i | ext_lo_en_i));
endmodule

bind ckp_chain ckp_chain_chk i_ckp_chain_chk (.*);

// File: tb/test_ckp_chain.sv
`timescale 1ns/1ps
module test_ckp_chain;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_src = '0, cfg_int = '0, cfg_per = '0;
  logic [3:0] cfg_bus = '0;
  logic ext_hi = 1'b0, pll = 1'b0, rc_lo = 1'b0, ext_lo = 1'b0;
  logic int_en, sys_en, bus_en, bus8_en, per_en, tmr_en;
  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  ckp_chain i_ckp_chain (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_src_i(cfg_src),
    .cfg_int_div_i(cfg_int), .cfg_bus_div_i(cfg_bus), .cfg_per_div_i(cfg_per),
    .ext_hi_en_i(ext_hi), .pll_en_i(pll), .rc_lo_en_i(rc_lo), .ext_lo_en_i(ext_lo),
    .int_en_o(int_en), .sys_en_o(sys_en), .bus_en_o(bus_en), .bus8_en_o(bus8_en),
    .per_en_o(per_en), .tmr_en_o(tmr_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic int sat(input int code, input int mx);
    return (code > mx) ? mx : code;
  endfunction

  // reference model: down-counters
  int m_src, m_int, m_bus, m_per;
  int sel, i_act, i_rem, b_act, b_rem, t_rem, p_act, p_rem;

  task automatic model_reset();
    m_src = 0; m_int = 0; m_bus = 0; m_per = 0; sel = 0;
    i_act = 0; i_rem = 0; b_act = 0; b_rem = 0; t_rem = 7; p_act = 0; p_rem = 0;
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      logic ie, se, be, te, pe, he, tm;
      logic [4:0] srcs;
      ie = (i_rem == 0);
      srcs = {ext_lo, rc_lo, pll, ext_hi, ie};
      se = srcs[sel];
      be = se && (b_rem == 0);
      te = be && (t_rem == 0);
      pe = be && (p_rem == 0);
      he = be && (p_act != 0) && (p_rem == ((1 << p_act) >> 1));
      tm = (p_act == 0) ? pe : (pe | he);
      chk("R2", int_en, ie);
      chk("R3 R4 R11", sys_en, se);
      chk("R5 R9", bus_en, be);
      chk("R6", bus8_en, te);
      chk("R7 R9", per_en, pe);
      chk("R8", tmr_en, tm);
      chk("R10", (bus8_en | per_en | tmr_en) & ~bus_en, 1'b0);
      // advance
      if (ie) begin i_act = sat(m_int, 7); i_rem = (1 << i_act) - 1; end
      else i_rem--;
      if (se) sel = (m_src > 4) ? 0 : m_src;
      if (se) begin
        if (b_rem == 0) begin b_act = sat(m_bus, 9); b_rem = (1 << b_act) - 1; end
        else b_rem--;
      end
      if (be) begin
        t_rem = (t_rem == 0) ? 7 : t_rem - 1;
        if (p_rem == 0) begin p_act = sat(m_per, 4); p_rem = (1 << p_act) - 1; end
        else p_rem--;
      end
      if (cfg_we) begin
        m_src = cfg_src; m_int = cfg_int; m_bus = cfg_bus; m_per = cfg_per;
      end
    end
  end

  task automatic step_rand(input int we_rate);
    @(posedge clk); #1;
    ext_hi = ($urandom % 2) == 0;
    pll    = ($urandom % 3) != 0;
    rc_lo  = ($urandom % 4) == 0;
    ext_lo = ($urandom % 9) == 0;
    cfg_src = 3'($urandom); cfg_int = 3'($urandom);
    cfg_bus = 4'($urandom); cfg_per = 3'($urandom);
    cfg_we = (we_rate > 0) && (($urandom % we_rate) == 0);
    if (cfg_we && ($urandom % 2 == 0)) begin
      cfg_int = 3'($urandom % 3); cfg_bus = 4'($urandom % 3);
    end
  endtask

  task automatic write_cfg(input int s, input int i, input int b, input int p);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_src = 3'(s); cfg_int = 3'(i); cfg_bus = 4'(b); cfg_per = 3'(p);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: first cycle after reset
    chk("R1", int_en, 1'b1);
    chk("R1", sys_en, 1'b1);
    chk("R1", bus_en, 1'b1);
    chk("R1", per_en, 1'b1);
    chk("R1", tmr_en, 1'b1);
    model_on = 1'b1;
    repeat (40) step_rand(0);
    // directed: per divisor 1 vs 2, saturating codes, bad source code
    write_cfg(0, 1, 0, 0);
    repeat (60) step_rand(0);
    write_cfg(0, 0, 1, 1);
    repeat (60) step_rand(0);
    write_cfg(6, 0, 15, 7);
    repeat (20000) step_rand(0);
    write_cfg(2, 0, 0, 2);
    repeat (400) step_rand(0);
    write_cfg(4, 0, 0, 0);
    repeat (400) step_rand(0);
    write_cfg(1, 2, 1, 3);
    repeat (2000) step_rand(0);
    repeat (60000) step_rand(150);
    @(negedge clk);
    model_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule